// File: doc/BRIEF.md
# Programmable Counter/Timer with Selectable Tick Source

This block is a down-counter whose function and tick source come from a 3-bit selection code. In one-shot counting it decrements from a loaded value and raises a sticky flag when it reaches zero. In periodic timing it reloads whenever it expires and flips an output, which gives a continuous square wave. Ticks come from one of four places: rising edges of an external pin, the 1x transmit strobe of serial channel A, the same strobe of serial channel B, or the system clock itself. Some codes add a divide-by-16 prescaler.

All tick sources are single-cycle enables in the system clock domain. A start pulse captures the selection code, loads the preset value and clears the prescaler. A stop pulse halts counting and drops the flag. The selection code is read only at a start, so software can set up the next mode while the current one keeps running.

Top module: `ctt_counter_timer`

## Requirements
- R1: After reset the count is zero, the ready flag and the wave output are low, and no tick source has any effect until a start.
- R2: A start loads the count from `preset`, clears ready and the wave output, latches `mode_sel` and clears the prescaler. Start takes priority over a stop or a tick in the same cycle, and the tick in the start cycle is lost.
- R3: Codes 0 to 3 select counting. Code 0 ticks on external pin rising edges, code 1 on the channel A strobe, code 2 on the channel B strobe, and code 3 on every system clock divided by 16.
- R4: Codes 4 to 7 select timing. Code 4 ticks on pin rising edges, code 5 on pin rising edges divided by 16, code 6 on every system clock, and code 7 on every system clock divided by 16.
- R5: In a divided code, a tick is produced on the 16th, 32nd, 48th, ... selected source strobe after the start.
- R6: When counting, each tick decrements the count modulo 2^CNT_W. A tick that takes the count from 1 to 0 sets ready. Ready stays set, and the count wraps to all ones and keeps decrementing.
- R7: When timing, a tick with count greater than 1 decrements. A tick with count of 0 or 1 reloads from `preset` and inverts the wave output. With preset P ≥ 1 the wave toggles every P ticks. Ready stays low when timing, and the wave output never changes when counting.
- R8: A stop without a start halts the count, clears ready and holds the count and wave output until the next start.
- R9: Changes of `mode_sel` after a start, and strobes on the sources that are not selected, do not affect the count, ready or wave.
- R10: The pin is sampled every clock, including while idle. A rising edge is a cycle in which the pin is high after being low in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Function and tick-source code, taken at start |
| preset | input | CNT_W | Load and reload value |
| start | input | 1 | Load preset and begin counting |
| stop | input | 1 | Halt counting and clear ready |
| ext_pin | input | 1 | External pin level, synchronous to clk |
| txa_tick | input | 1 | Channel A 1x transmit strobe |
| txb_tick | input | 1 | Channel B 1x transmit strobe |
| count | output | CNT_W | Present counter value |
| ready | output | 1 | Sticky zero-reached flag (counting) |
| wave_out | output | 1 | Square-wave output (timing) |

## Verification
The hardest states to reach are where the divide-by-16 prescaler and the reload point meet. One example is a timer reload that lands on the 16th source strobe while unrelated strobes keep arriving. Another is the counting wrap past zero with preset 0, which needs 2^CNT_W ticks. The bench uses an 8-bit counter so that every code can be swept against presets 0, 1, 3 and 11, with pseudo-random strobes on all sources and a change of the selection code halfway through each run. The expected count, flag and wave are derived arithmetically from the number of selected strobes delivered.

// File: rtl/ctt_pkg.sv
package ctt_pkg;

   typedef enum logic [1:0] {
      SRC_PIN = 2'd0,
      SRC_TXA = 2'd1,
      SRC_TXB = 2'd2,
      SRC_SYS = 2'd3
   } ctt_src_e;

   typedef struct packed {
      logic     periodic;
      logic     div_en;
      ctt_src_e src;
   } ctt_cfg_t;

   function automatic ctt_cfg_t ctt_decode(input logic [2:0] code);
      ctt_cfg_t c;
      c.periodic = code[2];
      case (code)
         3'd0:    begin c.src = SRC_PIN; c.div_en = 1'b0; end
         3'd1:    begin c.src = SRC_TXA; c.div_en = 1'b0; end
         3'd2:    begin c.src = SRC_TXB; c.div_en = 1'b0; end
         3'd3:    begin c.src = SRC_SYS; c.div_en = 1'b1; end
         3'd4:    begin c.src = SRC_PIN; c.div_en = 1'b0; end
         3'd5:    begin c.src = SRC_PIN; c.div_en = 1'b1; end
         3'd6:    begin c.src = SRC_SYS; c.div_en = 1'b0; end
         default: begin c.src = SRC_SYS; c.div_en = 1'b1; end
      endcase
      return c;
   endfunction

endpackage

// File: rtl/ctt_src_sel.sv
module ctt_src_sel
   import ctt_pkg::*;
(
   input  ctt_src_e src,
   input  logic     run,
   input  logic     pin_rise,
   input  logic     txa_tick,
   input  logic     txb_tick,
   output logic     raw_stb
);

   logic sel_stb;

   always_comb begin
      unique case (src)
         SRC_PIN: sel_stb = pin_rise;
         SRC_TXA: sel_stb = txa_tick;
         SRC_TXB: sel_stb = txb_tick;
         default: sel_stb = 1'b1;
      endcase
   end

   assign raw_stb = sel_stb & run;

endmodule

// File: rtl/ctt_prescale.sv
module ctt_prescale #(
   parameter int PRE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic div_en,
   input  logic in_stb,
   output logic out_stb
);

   generate
      if (PRE_W == 0) begin : g_bypass
         logic unused_ok;
         assign unused_ok = clk ^ rst_n ^ clr ^ div_en;
         assign out_stb   = in_stb;
      end else begin : g_div
         localparam logic [PRE_W-1:0] LAST = {PRE_W{1'b1}};
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk) begin
            if (!rst_n)
               pre_q <= '0;
            else if (clr)
               pre_q <= '0;
            else if (in_stb && div_en)
               pre_q <= pre_q + 1'b1;
         end

         assign out_stb = div_en ? (in_stb && (pre_q == LAST)) : in_stb;
      end
   endgenerate

endmodule

// File: rtl/ctt_core.sv
module ctt_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             stop,
   input  logic             tick,
   input  logic             periodic,
   input  logic [CNT_W-1:0] preset,
   output logic [CNT_W-1:0] count,
   output logic             ready,
   output logic             wave,
   output logic             run
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic expire;
   assign expire = (count <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         ready <= 1'b0;
         wave  <= 1'b0;
         run   <= 1'b0;
      end else if (start) begin
         count <= preset;
         ready <= 1'b0;
         wave  <= 1'b0;
         run   <= 1'b1;
      end else if (stop) begin
         ready <= 1'b0;
         run   <= 1'b0;
      end else if (run && tick) begin
         if (periodic) begin
            if (expire) begin
               count <= preset;
               wave  <= ~wave;
            end else begin
               count <= count - ONE;
            end
         end else begin
            count <= count - ONE;
            if (count == ONE)
               ready <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/ctt_counter_timer.sv
module ctt_counter_timer
   import ctt_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int PRE_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       mode_sel,
   input  logic [CNT_W-1:0] preset,
   input  logic             start,
   input  logic             stop,
   input  logic             ext_pin,
   input  logic             txa_tick,
   input  logic             txb_tick,
   output logic [CNT_W-1:0] count,
   output logic             ready,
   output logic             wave_out
);

   generate
      if (CNT_W < 2) begin : g_bad_cnt_w
         $error("ctt_counter_timer: CNT_W must be at least 2");
      end
      if (PRE_W < 0 || PRE_W > 8) begin : g_bad_pre_w
         $error("ctt_counter_timer: PRE_W must lie in 0..8");
      end
   endgenerate

   logic       pin_q;
   logic       pin_rise;
   logic [2:0] mode_q;
   ctt_cfg_t   cfg;
   logic       run;
   logic       raw_stb;
   logic       eff_tick;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pin_q  <= 1'b0;
         mode_q <= '0;
      end else begin
         pin_q <= ext_pin;
         if (start)
            mode_q <= mode_sel;
      end
   end

   assign pin_rise = ext_pin & ~pin_q;
   assign cfg      = ctt_decode(mode_q);

   ctt_src_sel i_src (
      .src      (cfg.src),
      .run      (run),
      .pin_rise (pin_rise),
      .txa_tick (txa_tick),
      .txb_tick (txb_tick),
      .raw_stb  (raw_stb)
   );

   ctt_prescale #(.PRE_W(PRE_W)) i_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (start),
      .div_en  (cfg.div_en),
      .in_stb  (raw_stb),
      .out_stb (eff_tick)
   );

   ctt_core #(.CNT_W(CNT_W)) i_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .stop     (stop),
      .tick     (eff_tick),
      .periodic (cfg.periodic),
      .preset   (preset),
      .count    (count),
      .ready    (ready),
      .wave     (wave_out),
      .run      (run)
   );

endmodule

// File: rtl/ctt_checker.sv
module ctt_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             stop,
   input logic [CNT_W-1:0] preset,
   input logic [2:0]       mode_q,
   input logic [CNT_W-1:0] count,
   input logic             ready,
   input logic             wave_out
);

   // R2: start loads the preset and clears the flag and wave
   a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (count == $past(preset)) && !ready && !wave_out);

   // R8: stop clears ready and holds the count
   a_r8_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && !start) |=> !ready && $stable(count));

   // R6: ready is sticky while counting
   a_r6_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start && !stop) |=> ready);

   // R6: counting steps down by at most one per clock
   a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !stop && !mode_q[2]) |=>
         ((count == $past(count)) || (count == $past(count) - 1'b1)));

   // R7: the wave never changes in counting mode
   a_r7_wave_quiet_counting: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && !mode_q[2]) |=> $stable(wave_out));

   // R7: the wave only flips at a reload
   a_r7_wave_only_on_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && mode_q[2] && (count > CNT_W'(1))) |=> $stable(wave_out));

   // R7: ready never rises while timing
   a_r7_no_ready_timing: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && mode_q[2]) |=> !ready);

endmodule

bind ctt_counter_timer ctt_checker #(.CNT_W(CNT_W)) i_ctt_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .start    (start),
   .stop     (stop),
   .preset   (preset),
   .mode_q   (mode_q),
   .count    (count),
   .ready    (ready),
   .wave_out (wave_out)
);

// File: tb/test_ctt_counter_timer.sv
module test_ctt_counter_timer;

   localparam int W    = 8;
   localparam int MODW = 1 << W;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   mode_sel = '0;
   logic [W-1:0] preset = '0;
   logic         start = 1'b0;
   logic         stop = 1'b0;
   logic         ext_pin = 1'b0;
   logic         txa_tick = 1'b0;
   logic         txb_tick = 1'b0;
   logic [W-1:0] count;
   logic         ready;
   logic         wave_out;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   logic  pin_prev = 1'b0;
   logic [15:0] lfsr = 16'hACE1;

   always #2.5 clk = ~clk;

   ctt_counter_timer #(.CNT_W(W), .PRE_W(4)) i_ctt_counter_timer (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .preset(preset),
      .start(start), .stop(stop), .ext_pin(ext_pin), .txa_tick(txa_tick),
      .txb_tick(txb_tick), .count(count), .ready(ready), .wave_out(wave_out)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // drive pseudo-random levels on all sources; returns selected strobe for mode m
   task automatic drive_noise(input int m, output int stb);
      logic p;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      p        = lfsr[0];
      txa_tick = lfsr[5];
      txb_tick = lfsr[9];
      ext_pin  = p;
      case (m)
         0, 4, 5: stb = (p && !pin_prev) ? 1 : 0;
         1:       stb = txa_tick ? 1 : 0;
         2:       stb = txb_tick ? 1 : 0;
         default: stb = 1;
      endcase
      pin_prev = p;
   endtask

   function automatic int exp_count(input int m, input int p, input int n);
      if (m >= 4) return (p == 0) ? 0 : p - (n % p);
      return (p - n) & (MODW - 1);
   endfunction

   function automatic int exp_ready(input int m, input int p, input int n);
      if (m >= 4) return 0;
      return (n >= ((p == 0) ? MODW : p)) ? 1 : 0;
   endfunction

   function automatic int exp_wave(input int m, input int p, input int n);
      if (m < 4) return 0;
      return (p == 0) ? (n & 1) : ((n / p) & 1);
   endfunction

   task automatic check_state(input int m, input int p, input int n, input string tag);
      chk({tag, " count"}, int'(count), exp_count(m, p, n));
      chk({tag, " ready"}, int'(ready), exp_ready(m, p, n));
      chk({tag, " wave"},  int'(wave_out), exp_wave(m, p, n));
   endtask

   task automatic run_case(input int m, input int p, input int len);
      int    nraw;
      int    neff;
      int    stb;
      bit    dv;
      string base;
      string tag;
      dv   = (m == 3 || m == 5 || m == 7);
      base = (m >= 4) ? "R4 R7" : "R3 R6";
      if (dv) base = {base, " R5"};
      if (m == 0 || m == 4 || m == 5) base = {base, " R10"};
      @(negedge clk);
      mode_sel = 3'(m);
      preset   = W'(p);
      start    = 1'b1;
      stop     = p[0];          // R2: start beats stop
      drive_noise(m, stb);      // strobe in start cycle is lost (R2)
      nraw = 0;
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         start = 1'b0;
         stop  = 1'b0;
         neff  = dv ? nraw / 16 : nraw;
         tag   = $sformatf("%s%s%s m=%0d p=%0d i=%0d", base,
                           (i == 0) ? " R2" : "", (i > len / 2) ? " R9" : "", m, p, i);
         check_state(m, p, neff, tag);
         if (i == len / 2) mode_sel = 3'(m) ^ 3'b101;   // R9: ignored until start
         drive_noise(m, stb);
         nraw += stb;
      end
      @(negedge clk);
      neff = dv ? nraw / 16 : nraw;
      check_state(m, p, neff, $sformatf("%s R9 m=%0d p=%0d end", base, m, p));
      stop = 1'b1;
      drive_noise(m, stb);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         stop = 1'b0;
         chk($sformatf("R8 count held m=%0d p=%0d k=%0d", m, p, k), int'(count), exp_count(m, p, neff));
         chk($sformatf("R8 ready clear m=%0d p=%0d k=%0d", m, p, k), int'(ready), 0);
         chk($sformatf("R8 wave held m=%0d p=%0d k=%0d", m, p, k), int'(wave_out), exp_wave(m, p, neff));
         drive_noise(m, stb);
      end
   endtask

   initial begin
      int presets[4] = '{0, 1, 3, 11};
      int dummy;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1: idle after reset, sources toggling have no effect
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         chk("R1 count", int'(count), 0);
         chk("R1 ready", int'(ready), 0);
         chk("R1 wave",  int'(wave_out), 0);
         mode_sel = 3'(k);
         drive_noise(6, dummy);
      end
      for (int m = 0; m < 8; m++)
         for (int j = 0; j < 4; j++)
            run_case(m, presets[j], 700);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule